// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets a clocked host use a 16-bit asynchronous static RAM with 19 address lines (512K words). The host places one request at a time on a request/acknowledge port. Each request carries an address, a write flag, a two-bit byte mask and write data. The controller then runs the memory's pins through a fixed sequence and raises a one-cycle done strobe when the access has finished. For reads, the done strobe comes with the returned word.

Every minimum time the memory needs is turned into a whole number of clock cycles when the design is elaborated. The conversion rounds the nanosecond figure up against a clock-period parameter. Write enable is always the signal that ends a write: address, chip selects and byte enables settle first and stay put until write enable has risen again. The bidirectional data bus is split into an output word, an input word and a drive enable, and the pad logic outside the block joins them. A fixed idle gap separates the end of a read from the first cycle the controller drives the bus.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is held and right after it, the memory is deselected: `mem_sel_n`=1 and `mem_sel`=0. `mem_we_n`=1, `mem_oe_n`=1, both byte-lane strobes are 1, `mem_dq_oe`=0, and `host_ack`=0 and `host_done`=0.
- R2: `mem_dq_oe` is never 1 in a cycle where `mem_oe_n` is 0.
- R3: A read holds the chip selected (`mem_sel_n`=0, `mem_sel`=1), `mem_oe_n`=0 and `mem_we_n`=1 for ceil(55 ns / period) cycles. The word is captured at the edge that ends the last of those cycles, and `host_done` is high in the following cycle. At 10 ns this gives `host_done` 7 cycles after the acknowledge cycle.
- R4: Host mask bit 0 drives `mem_lo_byte_n` low (data bits 7..0) and mask bit 1 drives `mem_hi_byte_n` low (bits 15..8). A write through one lane leaves the other lane of the stored word unchanged. A lane that was not requested reads back as zero in `host_rdata`.
- R5: `mem_we_n` stays low for max(ceil(40 ns/period), ceil(25 ns/period)) cycles. Address, chip selects and byte-lane strobes hold still from one cycle before `mem_we_n` falls until one cycle after it rises.
- R6: Write data is driven (`mem_dq_oe`=1) and held constant through the whole low phase of `mem_we_n` and the cycle after it.
- R7: When a write follows a read, there are at least ceil(20 ns/period) idle cycles with `mem_oe_n` high before the bus is driven. At 10 ns this makes that write's done strobe 9 cycles after its acknowledge instead of 7.
- R8: `host_ack` is high only while the controller is idle and `host_req` is high. Each accepted request gives exactly one single-cycle `host_done`. A write keeps the chip selected for at least ceil(55 ns/period) cycles.
- R9: A request with mask 00 leaves both byte-lane strobes high, writes nothing, returns zero on a read, and still completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | Request valid, held until acknowledged |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 19 | Word address |
| host_be | input | 2 | Byte mask, bit 0 low byte, bit 1 high byte |
| host_wdata | input | 16 | Write data |
| host_ack | output | 1 | Request accepted this cycle |
| host_done | output | 1 | One-cycle completion strobe |
| host_rdata | output | 16 | Read word, valid with host_done |
| mem_addr | output | 19 | Memory address |
| mem_sel_n | output | 1 | Active-low chip select |
| mem_sel | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lo_byte_n | output | 1 | Low byte-lane strobe, active low |
| mem_hi_byte_n | output | 1 | High byte-lane strobe, active low |
| mem_dq_out | output | 16 | Data toward the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 16 | Data from the memory |

## Verification
The case hardest to reach from the ports is a write that closely follows a read. This is where bus turnaround and write-enable timing interact, and the memory must not yet be driving the bus when data is applied. The bench therefore alternates reads and masked writes back to back to the same word. A behavioural memory model in the bench returns wrong data until the access time has passed. The same model measures, in nanoseconds, the write-enable pulse, the data setup and hold, and the gap between output enable rising and the bus being driven. A scoreboard checks each returned word and each done latency against values computed from the nanosecond figures.

// File: rtl/sramc_pkg.sv
// Package: shared state encoding and elaboration-time arithmetic for the
// asynchronous SRAM controller. Assumes all times are positive integers in ns.
package sramc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TURN,
        ST_RD,
        ST_WSET,
        ST_WPUL,
        ST_WHLD
    } sramc_state_e;

    // Ceiling division of two positive integers.
    function automatic int cdiv(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    // Larger of two integers.
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sramc_timer.sv
// Module: down-counting phase timer. Loaded with (cycles - 1) when the
// sequencer enters a timed phase; expired is high in the phase's last cycle.
// Assumes load values fit CNT_W bits.
module sramc_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    // Count down to zero, reload on each phase entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sramc_lanes.sv
// Module: byte-lane steering. Turns the latched host mask into the memory's
// active-low lane strobes and zeroes read lanes that were not requested.
// Assumes the lane strobes must be inactive whenever the chip is deselected.
module sramc_lanes #(
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input  logic                    sel,
    input  logic [LANES-1:0]        lane_en,
    input  logic [LANES*LANE_W-1:0] raw,
    output logic [LANES-1:0]        lane_n,
    output logic [LANES*LANE_W-1:0] masked
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Per lane: strobe only while selected; pass data only when requested.
        assign lane_n[g] = ~(sel & lane_en[g]);
        assign masked[g*LANE_W +: LANE_W] =
            lane_en[g] ? raw[g*LANE_W +: LANE_W] : '0;
    end

endmodule

// File: rtl/sramc_seq.sv
// Module: access sequencer. Accepts one host request while idle, latches it,
// and steps through read, write-setup, write-pulse, write-hold and
// turnaround phases whose lengths come from cycle-count parameters.
// Assumes every count parameter is at least 1 and fits CNT_W bits.
module sramc_seq
    import sramc_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 16,
    parameter int LANES  = 2,
    parameter int CNT_W  = 4,
    parameter int N_RD   = 6,
    parameter int N_WP   = 4,
    parameter int N_WH   = 1,
    parameter int N_WC   = 6,
    parameter int N_TURN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [LANES-1:0]  host_be,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_ack,
    output logic              host_done,
    output logic [DATA_W-1:0] host_rdata,
    input  logic [DATA_W-1:0] rd_word,
    input  logic [LANES-1:0]  lane_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              sel,
    output logic [LANES-1:0]  lane_en,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic              tmr_load,
    output logic [CNT_W-1:0]  tmr_val,
    input  logic              tmr_exp
);

    sramc_state_e      state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [LANES-1:0]  be_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              last_rd_q;
    logic              done_q;

    // Next phase from current phase, request and timer.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (host_req)
                         state_d = host_wr ? (last_rd_q ? ST_TURN : ST_WSET) : ST_RD;
            ST_TURN: if (tmr_exp) state_d = ST_WSET;
            ST_RD:   if (tmr_exp) state_d = ST_IDLE;
            ST_WSET: if (tmr_exp) state_d = ST_WPUL;
            ST_WPUL: if (tmr_exp) state_d = ST_WHLD;
            ST_WHLD: if (tmr_exp) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Timer reload value for the phase being entered.
    always_comb begin
        tmr_load = (state_d != state_q);
        unique case (state_d)
            ST_TURN: tmr_val = CNT_W'(N_TURN - 1);
            ST_RD:   tmr_val = CNT_W'(N_RD - 1);
            ST_WPUL: tmr_val = CNT_W'(N_WP - 1);
            ST_WHLD: tmr_val = CNT_W'(N_WH - 1);
            default: tmr_val = '0;
        endcase
    end

    // Phase register, request latch, read capture and done strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            addr_q    <= '0;
            be_q      <= '0;
            wdata_q   <= '0;
            rdata_q   <= '0;
            last_rd_q <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= ((state_q == ST_RD) || (state_q == ST_WHLD)) && tmr_exp;
            if (state_q == ST_IDLE && host_req) begin
                addr_q  <= host_addr;
                be_q    <= host_be;
                wdata_q <= host_wdata;
            end
            if (state_q == ST_RD && tmr_exp) begin
                rdata_q   <= rd_word;
                last_rd_q <= 1'b1;
            end
            if (state_q == ST_WHLD && tmr_exp) begin
                last_rd_q <= 1'b0;
            end
        end
    end

    // Pin decode from the phase register.
    assign host_ack   = (state_q == ST_IDLE) && host_req;
    assign host_done  = done_q;
    assign host_rdata = rdata_q;
    assign mem_addr   = addr_q;
    assign lane_en    = be_q;
    assign dq_out     = wdata_q;
    assign sel        = (state_q == ST_RD) || (state_q == ST_WSET) ||
                        (state_q == ST_WPUL) || (state_q == ST_WHLD);
    assign mem_oe_n   = (state_q != ST_RD);
    assign mem_we_n   = (state_q != ST_WPUL);
    assign dq_oe      = (state_q == ST_WPUL) || (state_q == ST_WHLD);

    // ---------------- checker counters and assertions ----------------
    logic [CNT_W:0] we_low_cnt, oe_low_cnt, oe_gap_cnt, sel_cnt;

    // Checker: run lengths of write enable low, output enable low,
    // output-enable-high gap (saturating) and chip-select time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_low_cnt <= '0;
            oe_low_cnt <= '0;
            oe_gap_cnt <= (CNT_W+1)'(N_TURN);
            sel_cnt    <= '0;
        end else begin
            we_low_cnt <= mem_we_n ? '0 : we_low_cnt + 1'b1;
            oe_low_cnt <= mem_oe_n ? '0 : oe_low_cnt + 1'b1;
            sel_cnt    <= sel ? sel_cnt + 1'b1 : '0;
            if (!mem_oe_n)
                oe_gap_cnt <= '0;
            else if (oe_gap_cnt < (CNT_W+1)'(N_TURN))
                oe_gap_cnt <= oe_gap_cnt + 1'b1;
        end
    end

    p_no_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> mem_oe_n);

    p_read_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n) |-> oe_low_cnt >= (CNT_W+1)'(N_RD));

    p_we_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> we_low_cnt >= (CNT_W+1)'(N_WP));

    p_we_ctl_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n || $rose(mem_we_n)) |->
            $stable(mem_addr) && $stable(lane_n) && sel && $past(sel));

    p_wdata_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && $past(!mem_we_n)) |-> $stable(dq_out) && dq_oe);

    p_wdata_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> dq_oe && $stable(dq_out));

    p_turn_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dq_oe) |-> oe_gap_cnt >= (CNT_W+1)'(N_TURN));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        host_done |=> !host_done);

    p_write_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sel) && $past(dq_oe)) |-> sel_cnt >= (CNT_W+1)'(N_WC));

endmodule

// File: rtl/sram_async_ctrl.sv
// Module: top of the asynchronous SRAM controller. Converts nanosecond
// timing figures into cycle counts, wires sequencer, phase timer and lane
// steering, and splits the chip selects into their two polarities.
// Assumes an external pad joins mem_dq_out/mem_dq_oe/mem_dq_in.
module sram_async_ctrl
    import sramc_pkg::*;
#(
    parameter int ADDR_W    = 19,
    parameter int LANE_W    = 8,
    parameter int CLK_NS    = 10,
    parameter int T_RC_NS   = 55,
    parameter int T_AA_NS   = 55,
    parameter int T_WC_NS   = 55,
    parameter int T_PWE_NS  = 40,
    parameter int T_SD_NS   = 25,
    parameter int T_HZWE_NS = 20,
    parameter int T_HZOE_NS = 18
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  host_req,
    input  logic                  host_wr,
    input  logic [ADDR_W-1:0]     host_addr,
    input  logic [1:0]            host_be,
    input  logic [2*LANE_W-1:0]   host_wdata,
    output logic                  host_ack,
    output logic                  host_done,
    output logic [2*LANE_W-1:0]   host_rdata,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic                  mem_sel_n,
    output logic                  mem_sel,
    output logic                  mem_we_n,
    output logic                  mem_oe_n,
    output logic                  mem_lo_byte_n,
    output logic                  mem_hi_byte_n,
    output logic [2*LANE_W-1:0]   mem_dq_out,
    output logic                  mem_dq_oe,
    input  logic [2*LANE_W-1:0]   mem_dq_in
);

    localparam int LANES  = 2;
    localparam int DATA_W = LANES * LANE_W;
    localparam int N_RD   = imax(cdiv(T_AA_NS, CLK_NS), cdiv(T_RC_NS, CLK_NS));
    localparam int N_WP   = imax(cdiv(T_PWE_NS, CLK_NS), cdiv(T_SD_NS, CLK_NS));
    localparam int N_WC   = cdiv(T_WC_NS, CLK_NS);
    localparam int N_WH   = imax(1, N_WC - 1 - N_WP);
    localparam int N_TURN = imax(cdiv(T_HZWE_NS, CLK_NS), cdiv(T_HZOE_NS, CLK_NS));
    localparam int N_MAX  = imax(imax(N_RD, N_WP), imax(N_WH, N_TURN));
    localparam int CNT_W  = $clog2(N_MAX + 1);

    logic              sel;
    logic [LANES-1:0]  lane_en;
    logic [LANES-1:0]  lane_n;
    logic [DATA_W-1:0] rd_word;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_exp;

    sramc_seq #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES), .CNT_W(CNT_W),
        .N_RD(N_RD), .N_WP(N_WP), .N_WH(N_WH), .N_WC(N_WC), .N_TURN(N_TURN)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .host_req(host_req), .host_wr(host_wr), .host_addr(host_addr),
        .host_be(host_be), .host_wdata(host_wdata),
        .host_ack(host_ack), .host_done(host_done), .host_rdata(host_rdata),
        .rd_word(rd_word), .lane_n(lane_n),
        .mem_addr(mem_addr), .sel(sel), .lane_en(lane_en),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .dq_out(mem_dq_out), .dq_oe(mem_dq_oe),
        .tmr_load(tmr_load), .tmr_val(tmr_val), .tmr_exp(tmr_exp)
    );

    sramc_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n),
        .load(tmr_load), .load_val(tmr_val), .expired(tmr_exp)
    );

    sramc_lanes #(.LANES(LANES), .LANE_W(LANE_W)) u_lanes (
        .sel(sel), .lane_en(lane_en), .raw(mem_dq_in),
        .lane_n(lane_n), .masked(rd_word)
    );

    // Two chip selects of opposite polarity from one select decision.
    assign mem_sel_n     = ~sel;
    assign mem_sel       = sel;
    assign mem_lo_byte_n = lane_n[0];
    assign mem_hi_byte_n = lane_n[1];

endmodule

// File: tb/sram_async_ctrl_test.sv
// Bench: scoreboard driver/monitor plus a behavioural asynchronous memory
// that returns wrong data before the access time and measures write timing.
module sram_async_ctrl_test;

    localparam int T_NS    = 10;
    localparam int LAT_RD  = (55 + T_NS - 1) / T_NS + 1;
    localparam int WP_CYC  = ((40 + T_NS - 1) / T_NS > (25 + T_NS - 1) / T_NS) ?
                             (40 + T_NS - 1) / T_NS : (25 + T_NS - 1) / T_NS;
    localparam int WH_CYC  = ((55 + T_NS - 1) / T_NS - 1 - WP_CYC > 1) ?
                             (55 + T_NS - 1) / T_NS - 1 - WP_CYC : 1;
    localparam int LAT_WR  = 1 + WP_CYC + WH_CYC + 1;
    localparam int TURN    = (20 + T_NS - 1) / T_NS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0, host_wr = 1'b0;
    logic [18:0] host_addr = '0;
    logic [1:0]  host_be = '0;
    logic [15:0] host_wdata = '0;
    logic        host_ack, host_done;
    logic [15:0] host_rdata;
    logic [18:0] mem_addr;
    logic        mem_sel_n, mem_sel, mem_we_n, mem_oe_n;
    logic        mem_lo_byte_n, mem_hi_byte_n, mem_dq_oe;
    logic [15:0] mem_dq_out;
    logic [15:0] mem_dq_in = 16'h5A5A;

    sram_async_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .host_req(host_req), .host_wr(host_wr), .host_addr(host_addr),
        .host_be(host_be), .host_wdata(host_wdata),
        .host_ack(host_ack), .host_done(host_done), .host_rdata(host_rdata),
        .mem_addr(mem_addr), .mem_sel_n(mem_sel_n), .mem_sel(mem_sel),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_lo_byte_n(mem_lo_byte_n), .mem_hi_byte_n(mem_hi_byte_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    always #5 clk = ~clk;

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit finished = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // ---------------- behavioural memory ----------------
    logic [15:0] mdl_mem [logic [18:0]];
    int          rd_age = 0, wl_cnt = 0, ds_cnt = 0, oe_hi_ns = 1000, contention = 0;
    logic [15:0] wl_data = '0;
    logic [18:0] wl_addr = '0, rd_addr = '0;
    logic [1:0]  wl_lanes = '0;
    logic        prev_dq_oe = 1'b0;

    function automatic logic [15:0] mdl_word(input logic [18:0] a);
        return mdl_mem.exists(a) ? mdl_mem[a] : 16'h0000;
    endfunction

    always @(negedge clk) begin
        logic selected;
        logic [1:0] lanes;
        logic [15:0] w, v;
        selected = !mem_sel_n && mem_sel;
        lanes = {~mem_hi_byte_n, ~mem_lo_byte_n};
        if (rst_n) begin
            // R2: never drive while the memory may drive
            if (mem_dq_oe && !mem_oe_n) contention++;
            // R7: drive start must follow 20 ns of output enable high
            oe_hi_ns = !mem_oe_n ? 0 : (oe_hi_ns < 1000 ? oe_hi_ns + T_NS : oe_hi_ns);
            if (mem_dq_oe && !prev_dq_oe) chk(oe_hi_ns >= 20, "R7 turnaround ns", oe_hi_ns, 20);
            prev_dq_oe = mem_dq_oe;
            // read path: data valid only once 55 ns have passed
            if (selected && !mem_oe_n && mem_we_n) begin
                rd_age = (rd_age != 0 && mem_addr == rd_addr) ? rd_age + 1 : 1;
                rd_addr = mem_addr;
                w = mdl_word(mem_addr);
                v = (rd_age * T_NS >= 55) ? w : ~w;
                if (!lanes[0]) v[7:0] = 8'hA5;
                if (!lanes[1]) v[15:8] = 8'hA5;
                mem_dq_in <= v;
            end else begin
                rd_age = 0;
                mem_dq_in <= 16'h5A5A;
            end
            // write path: write enable terminates, checks at its rising edge
            if (!mem_we_n && selected && (lanes != 2'b00)) begin
                if (wl_cnt == 0) wl_addr = mem_addr;
                wl_cnt++;
                wl_lanes = lanes;
                if (mem_dq_oe && (ds_cnt != 0) && mem_dq_out == wl_data) ds_cnt++;
                else begin wl_data = mem_dq_out; ds_cnt = mem_dq_oe ? 1 : 0; end
            end else if (wl_cnt > 0) begin
                chk(wl_cnt * T_NS >= 40, "R5 we pulse ns", wl_cnt * T_NS, 40);
                chk(ds_cnt * T_NS >= 25, "R6 data setup ns", ds_cnt * T_NS, 25);
                chk(selected && mem_addr == wl_addr && lanes == wl_lanes,
                    "R5 controls held past we", {13'd0, mem_addr}, {13'd0, wl_addr});
                chk(mem_dq_oe && mem_dq_out == wl_data, "R6 data hold", mem_dq_out, wl_data);
                w = mdl_word(wl_addr);
                if (wl_lanes[0]) w[7:0] = wl_data[7:0];
                if (wl_lanes[1]) w[15:8] = wl_data[15:8];
                mdl_mem[wl_addr] = w;
                wl_cnt = 0;
                ds_cnt = 0;
            end
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        logic        wr;
        logic [15:0] exp;
        int          ack_cyc;
        int          lat;
    } item_t;
    item_t       sb[$];
    logic [15:0] shadow [logic [18:0]];
    bit          prev_rd = 0;

    function automatic logic [15:0] sh_word(input logic [18:0] a);
        return shadow.exists(a) ? shadow[a] : 16'h0000;
    endfunction

    task automatic do_op(input logic wr, input logic [18:0] a,
                         input logic [1:0] be, input logic [15:0] d);
        item_t it;
        logic [15:0] w;
        @(negedge clk);
        host_req = 1'b1; host_wr = wr; host_addr = a; host_be = be; host_wdata = d;
        #1;
        while (!host_ack) begin @(negedge clk); #1; end
        w = sh_word(a);
        it.wr = wr;
        it.ack_cyc = cyc;
        if (wr) begin
            it.lat = prev_rd ? LAT_WR + TURN : LAT_WR;
            if (be[0]) w[7:0] = d[7:0];
            if (be[1]) w[15:8] = d[15:8];
            shadow[a] = w;
            it.exp = '0;
        end else begin
            it.lat = LAT_RD;
            it.exp = {be[1] ? w[15:8] : 8'h00, be[0] ? w[7:0] : 8'h00};
        end
        sb.push_back(it);
        prev_rd = !wr;
        @(negedge clk);
        host_req = 1'b0;
        if (!wr) begin
            // R3 select polarity and R4 lane strobes during the read
            chk(!mem_sel_n && mem_sel && !mem_oe_n && mem_we_n, "R3 read pins",
                {mem_sel_n, mem_sel, mem_oe_n, mem_we_n}, 4'b0101);
            chk({mem_hi_byte_n, mem_lo_byte_n} == ~be, "R4 lane strobes",
                {mem_hi_byte_n, mem_lo_byte_n}, ~be);
        end
    endtask

    // Monitor: pop on each done, compare latency and read data.
    always @(negedge clk) begin
        if (rst_n && host_done) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R8 done without request", 1, 0);
            end else begin
                item_t it;
                it = sb.pop_front();
                chk(cyc - it.ack_cyc == it.lat, it.wr ? "R8 write latency" : "R3 read latency",
                    cyc - it.ack_cyc, it.lat);
                if (!it.wr) chk(host_rdata == it.exp, "R4 read data", host_rdata, it.exp);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(mem_sel_n && !mem_sel && mem_we_n && mem_oe_n && mem_lo_byte_n &&
            mem_hi_byte_n && !mem_dq_oe && !host_done && !host_ack, "R1 reset pins",
            {mem_sel_n, mem_sel, mem_we_n, mem_oe_n, mem_lo_byte_n, mem_hi_byte_n, mem_dq_oe},
            7'b1011110);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_sel_n && !mem_sel && !mem_dq_oe, "R1 idle after reset",
            {mem_sel_n, mem_sel, mem_dq_oe}, 3'b100);

        do_op(1, 19'h00000, 2'b11, 16'h1234);
        do_op(1, 19'h7FFFF, 2'b11, 16'hBEEF);
        do_op(0, 19'h00000, 2'b11, 16'h0);     // R3 plain read
        do_op(1, 19'h00000, 2'b01, 16'h99AA);  // R7 write after read, low lane only
        do_op(0, 19'h00000, 2'b11, 16'h0);     // R4 expect 12AA
        do_op(1, 19'h00000, 2'b10, 16'h5677);  // R4 high lane only
        do_op(0, 19'h00000, 2'b01, 16'h0);     // R4 upper lane returns zero
        do_op(0, 19'h00000, 2'b10, 16'h0);
        do_op(1, 19'h00000, 2'b00, 16'hFFFF);  // R9 empty mask write
        do_op(0, 19'h00000, 2'b00, 16'h0);     // R9 empty mask read returns zero
        do_op(0, 19'h00000, 2'b11, 16'h0);     // R9 word unchanged (56AA)
        do_op(0, 19'h7FFFF, 2'b11, 16'h0);
        for (int i = 0; i < 12; i++)
            do_op(1, 19'(i * 4099 + 7), 2'b11, 16'(16'hC300 ^ (i * 16'h0111)));
        for (int i = 0; i < 12; i++)
            do_op(0, 19'(i * 4099 + 7), (i % 3 == 0) ? 2'b01 : 2'b11, 16'h0);

        while (sb.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(contention == 0, "R2 bus contention cycles", contention, 0);
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            chk(1'b0, "watchdog R8", cyc, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule